// File: doc/BRIEF.md
# Split Status Flag Register

This block keeps a processor's status flags in three groups, and each group is written on its own. The first group holds the four arithmetic condition flags: negative, zero, carry and overflow. The second group is the sticky saturation flag. The third group holds the four per-lane greater-or-equal flags that packed arithmetic produces. Each execution path writes only its own group. A partial flag update therefore never has to read the other groups back and merge them. A separate register holds all the status bits that are not flags.

The block rebuilds the 32-bit status word from the groups combinationally. Reads and trace use that word. When an exception is taken, the word is also captured into a saved-status register. A full 32-bit status write is split back into the groups with fixed masks. The block also evaluates the instruction condition predicate from the stored arithmetic flags, and it outputs the stored carry for the shifter.

All pins are plain control and status signals. Nothing flows as a stream, so no pin has a valid/ready handshake and nothing can stall. Every write is accepted on the clock edge where its enable is high.

Top module: `sflag_split_status`

## Requirements
- R1: After reset, every flag group is zero, the non-flag bits hold the reset value (default zero), and `saved_status` is zero.
- R2: With `nzcv_we`=1, `nz_only`=0 and `full_we`=0, the next status word carries `nzcv_in` at bits 31:28. N is at bit 31, Z at 30, C at 29 and V at 28, and `nzcv_in` is ordered {N,Z,C,V}.
- R3: With `nzcv_we`=1 and `nz_only`=1, only N and Z take `nzcv_in[3:2]`. C and V keep their old values.
- R4: Q sits at bit 27 and is sticky. The next Q is the old Q ORed with `q_set`, so `q_set`=0 leaves Q unchanged. Only a full write can clear Q.
- R5: With `ge_we`=1, all four GE bits (bits 19:16) are replaced by `ge_in`. The old bits are not merged in.
- R6: With `full_we`=1, each group takes `full_in` ANDed with its mask (NZCV 0xF0000000, Q 0x08000000, GE 0x000F0000). The bits outside 0xF80F0000 go to the non-flag register. The next status word therefore equals `full_in`.
- R7: When `full_we` is high in the same cycle as `nzcv_we`, `q_set` or `ge_we`, the full write wins for every group.
- R8: `status_out` is the non-flag bits ORed with the three groups. `carry_out` equals the stored C. Group writes never change the non-flag bits.
- R9: `cond_pass` is combinational from the stored flags for condition codes 0 to 13: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R10: Codes 14 (always) and 15 (unconditional) pass for any stored flag value.
- R11: With `exc_take`=1, `saved_status` takes the status word as it stood before that edge. Otherwise `saved_status` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nzcv_we | input | 1 | Arithmetic flag group write |
| nz_only | input | 1 | Restrict the arithmetic write to N and Z |
| nzcv_in | input | 4 | New {N,Z,C,V} |
| q_set | input | 1 | Saturation indication, ORed into Q |
| ge_we | input | 1 | GE group write |
| ge_in | input | 4 | New GE bits, lane 3 down to lane 0 |
| full_we | input | 1 | Full status word write |
| full_in | input | 32 | Full status word |
| exc_take | input | 1 | Capture the status word on exception entry |
| cond_in | input | 4 | Condition code to evaluate |
| status_out | output | 32 | Merged status word |
| saved_status | output | 32 | Status word captured on exception entry |
| cond_pass | output | 1 | Condition predicate result |
| carry_out | output | 1 | Stored C, used as the shifter carry input |

## Verification
Every write and every exception capture shows on `status_out` and `saved_status` one cycle after the edge that samples it. The driver applies a stimulus at a falling edge and queues the word expected after the next rising edge. The monitor compares each queued entry shortly after that rising edge, so the comparison always refers to that single edge. `cond_pass` has no register in its path. It is checked a short delay after `cond_in` changes in a quiet cycle, once for each stored flag pattern.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int SW      = 32;
  localparam int N_BIT   = 31;
  localparam int Z_BIT   = 30;
  localparam int C_BIT   = 29;
  localparam int V_BIT   = 28;
  localparam int Q_BIT   = 27;
  localparam int GE_LO   = 16;
  localparam int GE_W    = 4;
  localparam int GE_HI   = GE_LO + GE_W - 1;

  localparam logic [SW-1:0] MASK_NZCV  = 32'hF000_0000;
  localparam logic [SW-1:0] MASK_Q     = 32'h0800_0000;
  localparam logic [SW-1:0] MASK_GE    = 32'h000F_0000;
  localparam logic [SW-1:0] MASK_FLAGS = MASK_NZCV | MASK_Q | MASK_GE;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_UC = 4'd15
  } cond_e;
endpackage

// File: rtl/sflag_nzcv_grp.sv
module sflag_nzcv_grp
  import sflag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  logic  nz_only,
  input  nzcv_t wr_val,
  input  logic  full_we,
  input  nzcv_t full_val,
  output nzcv_t flags
);
  nzcv_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (full_we) begin
      flags_q <= full_val;
    end else if (we) begin
      flags_q.n <= wr_val.n;
      flags_q.z <= wr_val.z;
      if (!nz_only) begin
        flags_q.c <= wr_val.c;
        flags_q.v <= wr_val.v;
      end
    end
  end

  assign flags = flags_q;

  // R3: a multiply-class update keeps C and V
  a_r3_cv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (we && nz_only && !full_we) |=> (flags.c == $past(flags.c)) && (flags.v == $past(flags.v)));

  // R2: a full-group update lands all four flags
  a_r2_nzcv_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !nz_only && !full_we) |=> flags == $past(wr_val));
endmodule

// File: rtl/sflag_q_grp.sv
module sflag_q_grp (
  input  logic clk,
  input  logic rst_n,
  input  logic sat_in,
  input  logic full_we,
  input  logic full_val,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)       q_r <= 1'b0;
    else if (full_we) q_r <= full_val;
    else if (sat_in)  q_r <= 1'b1;
  end

  assign q = q_r;

  // R4: once set, Q stays set until a full write
  a_r4_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !full_we) |=> q);
endmodule

// File: rtl/sflag_ge_grp.sv
module sflag_ge_grp #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wr_val,
  input  logic         full_we,
  input  logic [W-1:0] full_val,
  output logic [W-1:0] ge
);
  logic [W-1:0] ge_r;

  always_ff @(posedge clk) begin
    if (!rst_n)       ge_r <= '0;
    else if (full_we) ge_r <= full_val;
    else if (we)      ge_r <= wr_val;
  end

  assign ge = ge_r;

  // R5: a GE write replaces the whole group
  a_r5_ge_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !full_we) |=> ge == $past(wr_val));
endmodule

// File: rtl/sflag_cond_eval.sv
module sflag_cond_eval
  import sflag_pkg::*;
(
  input  nzcv_t      f,
  input  logic [3:0] cond,
  output logic       pass
);
  logic nv_eq;
  assign nv_eq = (f.n == f.v);

  always_comb begin
    unique case (cond_e'(cond))
      CC_EQ:   pass = f.z;
      CC_NE:   pass = !f.z;
      CC_CS:   pass = f.c;
      CC_CC:   pass = !f.c;
      CC_MI:   pass = f.n;
      CC_PL:   pass = !f.n;
      CC_VS:   pass = f.v;
      CC_VC:   pass = !f.v;
      CC_HI:   pass = f.c && !f.z;
      CC_LS:   pass = !f.c || f.z;
      CC_GE:   pass = nv_eq;
      CC_LT:   pass = !nv_eq;
      CC_GT:   pass = !f.z && nv_eq;
      CC_LE:   pass = f.z || !nv_eq;
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/sflag_split_status.sv
module sflag_split_status
  import sflag_pkg::*;
#(
  parameter logic [31:0] OTHER_RST = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nzcv_we,
  input  logic        nz_only,
  input  logic [3:0]  nzcv_in,
  input  logic        q_set,
  input  logic        ge_we,
  input  logic [3:0]  ge_in,
  input  logic        full_we,
  input  logic [31:0] full_in,
  input  logic        exc_take,
  input  logic [3:0]  cond_in,
  output logic [31:0] status_out,
  output logic [31:0] saved_status,
  output logic        cond_pass,
  output logic        carry_out
);
  localparam logic [SW-1:0] OTHER_MASK = ~MASK_FLAGS;

  nzcv_t           nzcv_cur;
  logic            q_cur;
  logic [GE_W-1:0] ge_cur;
  logic [SW-1:0]   other_r;
  logic [SW-1:0]   saved_r;
  logic [SW-1:0]   merged;

  sflag_nzcv_grp u_nzcv (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (nzcv_we),
    .nz_only  (nz_only),
    .wr_val   (nzcv_t'(nzcv_in)),
    .full_we  (full_we),
    .full_val (nzcv_t'(full_in[N_BIT:V_BIT])),
    .flags    (nzcv_cur)
  );

  sflag_q_grp u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .sat_in   (q_set),
    .full_we  (full_we),
    .full_val (full_in[Q_BIT]),
    .q        (q_cur)
  );

  sflag_ge_grp #(.W(GE_W)) u_ge (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ge_we),
    .wr_val   (ge_in),
    .full_we  (full_we),
    .full_val (full_in[GE_HI:GE_LO]),
    .ge       (ge_cur)
  );

  sflag_cond_eval u_cond (
    .f    (nzcv_cur),
    .cond (cond_in),
    .pass (cond_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       other_r <= OTHER_RST & OTHER_MASK;
    else if (full_we) other_r <= full_in & OTHER_MASK;
  end

  always_comb begin
    merged = other_r;
    merged[N_BIT:V_BIT] = nzcv_cur;
    merged[Q_BIT] = q_cur;
    merged[GE_HI:GE_LO] = ge_cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        saved_r <= '0;
    else if (exc_take) saved_r <= merged;
  end

  assign status_out   = merged;
  assign saved_status = saved_r;
  assign carry_out    = nzcv_cur.c;

  // R6/R7: a full write wins and the word reads back intact
  a_r7_full_prio: assert property (@(posedge clk) disable iff (!rst_n)
    full_we |=> status_out == $past(full_in));

  // R8: group writes leave non-flag bits alone
  a_r8_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !full_we |=> (status_out & OTHER_MASK) == $past(status_out & OTHER_MASK));

  // R11: snapshot holds between exceptions
  a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(saved_status));

  // R10: always and unconditional codes pass
  a_r10_always_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_in[3:1] == 3'b111) |-> cond_pass);
endmodule

// File: tb/sflag_split_status_tb.sv
module sflag_split_status_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nzcv_we = 0, nz_only = 0, q_set = 0, ge_we = 0, full_we = 0, exc_take = 0;
  logic [3:0]  nzcv_in = 0, ge_in = 0, cond_in = 0;
  logic [31:0] full_in = 0;
  logic [31:0] status_out, saved_status;
  logic        cond_pass, carry_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_st_q[$];
  logic [31:0] exp_sv_q[$];
  string       tag_q[$];

  logic [3:0]  m_nzcv = 0;
  logic        m_q = 0;
  logic [3:0]  m_ge = 0;
  logic [31:0] m_other = 0;
  logic [31:0] m_saved = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflag_split_status u_dut (
    .clk(clk), .rst_n(rst_n), .nzcv_we(nzcv_we), .nz_only(nz_only),
    .nzcv_in(nzcv_in), .q_set(q_set), .ge_we(ge_we), .ge_in(ge_in),
    .full_we(full_we), .full_in(full_in), .exc_take(exc_take),
    .cond_in(cond_in), .status_out(status_out), .saved_status(saved_status),
    .cond_pass(cond_pass), .carry_out(carry_out)
  );

  function automatic logic [31:0] model_word();
    return m_other | {m_nzcv, 28'h0} | ({31'h0, m_q} << 27) | ({28'h0, m_ge} << 16);
  endfunction

  function automatic logic cond_model(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;       4'd1: return !z;
      4'd2: return cy;      4'd3: return !cy;
      4'd4: return n;       4'd5: return !n;
      4'd6: return v;       4'd7: return !v;
      4'd8: return cy && !z; 4'd9: return !cy || z;
      4'd10: return n == v; 4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic nzw, input logic nzo, input logic [3:0] nzi,
                      input logic qs, input logic gew, input logic [3:0] gei,
                      input logic fw, input logic [31:0] fi, input logic ex,
                      input string tag);
    @(negedge clk);
    nzcv_we = nzw; nz_only = nzo; nzcv_in = nzi; q_set = qs;
    ge_we = gew; ge_in = gei; full_we = fw; full_in = fi; exc_take = ex;
    if (ex) m_saved = model_word();
    if (fw) begin
      m_nzcv = fi[31:28]; m_q = fi[27]; m_ge = fi[19:16];
      m_other = fi & ~32'hF80F_0000;
    end else begin
      if (nzw) begin
        if (nzo) m_nzcv[3:2] = nzi[3:2];
        else     m_nzcv = nzi;
      end
      m_q = m_q | qs;
      if (gew) m_ge = gei;
    end
    exp_st_q.push_back(model_word());
    exp_sv_q.push_back(m_saved);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    nzcv_we = 0; nz_only = 0; q_set = 0; ge_we = 0; full_we = 0; exc_take = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
  endtask

  // Monitor: compares results one rising edge after each stimulus
  always @(posedge clk) begin
    #1;
    if (exp_st_q.size() != 0) begin
      logic [31:0] es, ev;
      string t;
      es = exp_st_q.pop_front();
      ev = exp_sv_q.pop_front();
      t  = tag_q.pop_front();
      check({t, " status"}, status_out, es);
      check({t, " saved"}, saved_status, ev);
      check("R8 carry", {31'h0, carry_out}, {31'h0, es[29]});
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset status", status_out, 32'h0);
    check("R1 reset saved", saved_status, 32'h0);

    step(1, 0, 4'b1010, 0, 0, 0, 0, 0, 0, "R2 nzcv 1010");
    step(1, 0, 4'b0101, 0, 0, 0, 0, 0, 0, "R2 nzcv 0101");
    step(1, 1, 4'b1100, 0, 0, 0, 0, 0, 0, "R3 nz only keeps CV");
    step(1, 1, 4'b0011, 0, 0, 0, 0, 0, 0, "R3 nz only ignores low");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4 q set");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 q stays");
    step(1, 0, 4'b0000, 0, 0, 0, 0, 0, 0, "R4 q survives nzcv write");
    step(0, 0, 0, 0, 1, 4'b1111, 0, 0, 0, "R5 ge all");
    step(0, 0, 0, 0, 1, 4'b0010, 0, 0, 0, "R5 ge replace");
    step(0, 0, 0, 0, 0, 0, 1, 32'h1234_5678, 0, "R6 full split");
    step(1, 0, 4'b1111, 1, 1, 4'b0101, 0, 0, 0, "R8 group writes keep other");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 snapshot");
    idle();
    step(1, 0, 4'b1111, 1, 1, 4'b1111, 1, 32'h0000_00D3, 1, "R7 full wins");
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, "R6 full ones");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 snapshot ones");

    for (int p = 0; p < 16; p++) begin
      step(0, 0, 0, 0, 0, 0, 1, {p[3:0], 28'h0}, 0, "R9 load flags");
      for (int c = 0; c < 16; c++) begin
        cond_in = c[3:0];
        #1;
        check(c >= 14 ? "R10 always pass" : "R9 cond", {31'h0, cond_pass},
              {31'h0, cond_model(p[3:0], c[3:0])});
      end
      cond_in = 0;
    end

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule